// File: doc/BRIEF.md
# Conditional Branch Execution Unit

This block executes the conditional-jump, compare-and-jump, decrement-and-jump and indirect-jump instructions of an 8051-compatible core, together with the no-operation opcodes. It runs without pause from reset. Each instruction is fetched over a synchronous code-memory read port: the address is driven in one clock and the byte comes back in the next. Registers R0 to R7, direct bytes and bit-addressable bytes are read and written over a single-port, synchronous-read internal data RAM port. The block owns the program counter and the carry flag. The accumulator, the data pointer and the two register-bank bits come in as inputs from the rest of the core.

An instruction cycle is four clocks long. Every opcode takes a fixed number of instruction cycles, which is often more than its byte count. The timing is therefore deterministic and software loops can be timed from the opcode alone. When an instruction retires, the block pulses a done strobe for one clock. In that clock it reports the retired opcode and the number of clocks the instruction took, and the program counter and carry already hold their new values.

Top module: `cbr_exec`

## Requirements
- R1: While reset is high and in the first clock after it, pc is 0, cy is 0, done is low, and the first fetch is from code address 0.
- R2: Every instruction occupies exactly 4 × N clocks. done goes high for one clock after the last of them, with done_clks = 4 × N. N is 1 for 0x00, 0xA5 and unlisted opcodes. N is 3 for 0x60, 0x70, 0xD8–0xDF and 0x73. N is 4 for 0x30, 0x10, 0xB4–0xBF and 0xD5.
- R3: 0x00, the reserved 0xA5 and any unlisted opcode are one byte long: pc advances by 1, and cy and RAM are unchanged.
- R4: 0x60 jumps when acc is zero and 0x70 jumps when acc is nonzero. Both are two bytes, with the offset in byte 1. If the jump is not taken, pc = pc+2.
- R5: For 0x30 and 0x10, byte 1 is a bit address and byte 2 the offset. Bits 6:3 of the bit address pick RAM byte 0x20+value, bits 2:0 pick the bit, and bit 7 is ignored. 0x30 jumps when the bit is 0. 0x10 jumps when the bit is 1 and writes that bit back as 0; it writes nothing when the bit is 0.
- R6: The compare-and-jump forms are three bytes, with the offset in byte 2, and jump when the two operands differ. 0xB4 compares acc with immediate byte 1. 0xB5 compares acc with RAM[byte 1]. 0xB6/0xB7 compare RAM[R0/R1] with immediate byte 1. 0xB8–0xBF compare Rn (n = opcode bits 2:0) with immediate byte 1.
- R7: Every compare-and-jump sets cy when its first operand is unsigned-less than its second and clears cy otherwise, whether or not the jump is taken.
- R8: 0xD8–0xDF (Rn, offset in byte 1, two bytes) and 0xD5 (RAM[byte 1], offset in byte 2, three bytes) write operand−1 mod 256 back to the same location and jump when that result is nonzero.
- R9: Rn lives at RAM address bank_sel×8+n. For 0xB6/0xB7 the pointer is R0/R1 of the selected bank.
- R10: 0x73 loads pc with acc+dptr, wrapping at 16 bits.
- R11: A taken relative jump sets pc to the address after the whole instruction plus the sign-extended offset (two's complement). Backward and forward offsets both work.
- R12: cy changes only on compare-and-jump opcodes. RAM is written only by the decrement forms and by 0x10 on a set bit, once per instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_addr | output | 16 | Code-memory read address |
| code_data | input | 8 | Code byte returned one clock after its address |
| ram_addr | output | 8 | Data RAM address for both read and write |
| ram_rdata | input | 8 | RAM byte returned one clock after its address |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| bank_sel | input | 2 | Register bank select |
| pc | output | 16 | Program counter |
| cy | output | 1 | Carry flag |
| done | output | 1 | One-clock pulse when an instruction retires |
| done_op | output | 8 | Opcode of the retired instruction |
| done_clks | output | 5 | Clock count of the retired instruction |

## Verification
Several internal faults show up at the ports, each at a different point. A miscounted micro-step or cycle length moves the done pulse off its four-clock grid, and this is visible in the very clock the pulse is expected. A wrong operand address, bank or pointer is silent until it reaches the retiring instruction. There it appears as a wrong pc, a wrong carry, or a RAM byte that differs from a reference copy, all observable one clock after the last instruction cycle. A stale decrement or a lost bit clear stays hidden until a loop runs a different number of times, so program paths that revisit the same location expose it.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int CLKS_PER_IC = 4;
    localparam int MAX_IC      = 4;
    localparam int CNT_W       = $clog2(CLKS_PER_IC * MAX_IC + 1);

    // fixed micro-step schedule inside an instruction
    localparam int STEP_OP = 1;
    localparam int STEP_B1 = 2;
    localparam int STEP_B2 = 3;
    localparam int STEP_RA = 4;
    localparam int STEP_RI = 5;
    localparam int STEP_RD = 6;
    localparam int STEP_WR = 7;

    typedef enum logic [3:0] {
        K_IDLE, K_JACC0, K_JACCNZ, K_JBIT0, K_JBITCLR,
        K_CMP_AD, K_CMP_AI, K_CMP_IND, K_CMP_REG,
        K_DEC_REG, K_DEC_DIR, K_JIND
    } kind_t;

    typedef struct packed {
        kind_t      kind;
        logic [1:0] nbytes;
        logic [2:0] ncyc;
        logic       indirect;
    } dec_t;

    function automatic dec_t decode_op(input logic [7:0] op);
        dec_t d;
        d = '{kind: K_IDLE, nbytes: 2'd1, ncyc: 3'd1, indirect: 1'b0};
        casez (op)
            8'h60:        d = '{K_JACC0,   2'd2, 3'd3, 1'b0};
            8'h70:        d = '{K_JACCNZ,  2'd2, 3'd3, 1'b0};
            8'h30:        d = '{K_JBIT0,   2'd3, 3'd4, 1'b0};
            8'h10:        d = '{K_JBITCLR, 2'd3, 3'd4, 1'b0};
            8'hB5:        d = '{K_CMP_AD,  2'd3, 3'd4, 1'b0};
            8'hB4:        d = '{K_CMP_AI,  2'd3, 3'd4, 1'b0};
            8'b1011_011?: d = '{K_CMP_IND, 2'd3, 3'd4, 1'b1};
            8'b1011_1???: d = '{K_CMP_REG, 2'd3, 3'd4, 1'b0};
            8'b1101_1???: d = '{K_DEC_REG, 2'd2, 3'd3, 1'b0};
            8'hD5:        d = '{K_DEC_DIR, 2'd3, 3'd4, 1'b0};
            8'h73:        d = '{K_JIND,    2'd1, 3'd3, 1'b0};
            default:      ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
    import cbr_pkg::*;
(
    input  logic [7:0] op,
    input  logic [7:0] b1,
    input  logic [1:0] bank_sel,
    output dec_t       dec,
    output logic [7:0] first_addr
);
    always_comb begin
        dec = decode_op(op);
        unique case (dec.kind)
            K_JBIT0, K_JBITCLR:   first_addr = {4'b0010, b1[6:3]};
            K_CMP_AD, K_DEC_DIR:  first_addr = b1;
            K_CMP_IND:            first_addr = {3'b000, bank_sel, 2'b00, op[0]};
            K_CMP_REG, K_DEC_REG: first_addr = {3'b000, bank_sel, op[2:0]};
            default:              first_addr = 8'h00;
        endcase
    end
endmodule

// File: rtl/cbr_resolve.sv
module cbr_resolve
    import cbr_pkg::*;
#(
    parameter int PCW = 16
) (
    input  dec_t           dec,
    input  logic [PCW-1:0] pc,
    input  logic [7:0]     b1,
    input  logic [7:0]     b2,
    input  logic [7:0]     opnd,
    input  logic [7:0]     acc,
    input  logic [PCW-1:0] dptr,
    input  logic           cy_in,
    output logic [PCW-1:0] next_pc,
    output logic           cy_out,
    output logic           wr_need,
    output logic [7:0]     wr_data
);
    logic [PCW-1:0] seq_pc, tgt_pc;
    logic [7:0]     rel, lhs, rhs, dec_val;
    logic [2:0]     bidx;
    logic           bitv, take;

    always_comb begin
        seq_pc  = pc + PCW'(dec.nbytes);
        rel     = (dec.nbytes == 2'd2) ? b1 : b2;
        tgt_pc  = seq_pc + {{(PCW-8){rel[7]}}, rel};
        bidx    = b1[2:0];
        bitv    = opnd[bidx];
        dec_val = opnd - 8'd1;
        lhs     = (dec.kind == K_CMP_AD || dec.kind == K_CMP_AI) ? acc : opnd;
        rhs     = (dec.kind == K_CMP_AD) ? opnd : b1;
        take    = 1'b0;
        cy_out  = cy_in;
        wr_need = 1'b0;
        wr_data = dec_val;
        unique case (dec.kind)
            K_JACC0:   take = (acc == 8'h00);
            K_JACCNZ:  take = (acc != 8'h00);
            K_JBIT0:   take = !bitv;
            K_JBITCLR: begin
                take    = bitv;
                wr_need = bitv;
                wr_data = opnd & ~(8'h01 << bidx);
            end
            K_CMP_AD, K_CMP_AI, K_CMP_IND, K_CMP_REG: begin
                take   = (lhs != rhs);
                cy_out = (lhs < rhs);
            end
            K_DEC_REG, K_DEC_DIR: begin
                take    = (dec_val != 8'h00);
                wr_need = 1'b1;
            end
            default: ;
        endcase
        if (dec.kind == K_JIND)
            next_pc = PCW'(acc) + dptr;
        else
            next_pc = take ? tgt_pc : seq_pc;
    end
endmodule

// File: rtl/cbr_exec.sv
module cbr_exec
    import cbr_pkg::*;
#(
    parameter int PCW = 16
) (
    input  logic             clk,
    input  logic             rst,
    output logic [PCW-1:0]   code_addr,
    input  logic [7:0]       code_data,
    output logic [7:0]       ram_addr,
    input  logic [7:0]       ram_rdata,
    output logic             ram_we,
    output logic [7:0]       ram_wdata,
    input  logic [7:0]       acc,
    input  logic [PCW-1:0]   dptr,
    input  logic [1:0]       bank_sel,
    output logic [PCW-1:0]   pc,
    output logic             cy,
    output logic             done,
    output logic [7:0]       done_op,
    output logic [CNT_W-1:0] done_clks
);
    logic [CNT_W-1:0] cnt, span;
    logic [7:0]       op_q, b1, b2, opnd, raddr, first_addr, wr_data;
    dec_t             dec;
    logic [PCW-1:0]   next_pc;
    logic             cy_next, wr_need, last;

    cbr_decode u_dec (
        .op(op_q), .b1(b1), .bank_sel(bank_sel),
        .dec(dec), .first_addr(first_addr)
    );

    cbr_resolve #(.PCW(PCW)) u_res (
        .dec(dec), .pc(pc), .b1(b1), .b2(b2), .opnd(opnd),
        .acc(acc), .dptr(dptr), .cy_in(cy),
        .next_pc(next_pc), .cy_out(cy_next),
        .wr_need(wr_need), .wr_data(wr_data)
    );

    always_comb begin
        span = CNT_W'(int'(dec.ncyc) * CLKS_PER_IC);
        last = (cnt >= CNT_W'(STEP_B1)) && (cnt == span - CNT_W'(1));

        if (cnt == CNT_W'(STEP_OP))      code_addr = pc + PCW'(1);
        else if (cnt == CNT_W'(STEP_B1)) code_addr = pc + PCW'(2);
        else                             code_addr = pc;

        if (cnt == CNT_W'(STEP_RA))                     ram_addr = first_addr;
        else if (cnt == CNT_W'(STEP_RI) && dec.indirect) ram_addr = ram_rdata;
        else                                            ram_addr = raddr;

        ram_we    = (cnt == CNT_W'(STEP_WR)) && wr_need;
        ram_wdata = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            pc        <= '0;
            cy        <= 1'b0;
            op_q      <= 8'h00;
            b1        <= 8'h00;
            b2        <= 8'h00;
            opnd      <= 8'h00;
            raddr     <= 8'h00;
            done      <= 1'b0;
            done_op   <= 8'h00;
            done_clks <= '0;
        end else begin
            if (cnt == CNT_W'(STEP_OP)) op_q  <= code_data;
            if (cnt == CNT_W'(STEP_B1)) b1    <= code_data;
            if (cnt == CNT_W'(STEP_B2)) b2    <= code_data;
            if (cnt == CNT_W'(STEP_RA)) raddr <= first_addr;
            if (cnt == CNT_W'(STEP_RI) && dec.indirect) raddr <= ram_rdata;
            if (cnt == CNT_W'(STEP_RD)) opnd  <= ram_rdata;
            if (last) begin
                pc        <= next_pc;
                cy        <= cy_next;
                done      <= 1'b1;
                done_op   <= op_q;
                done_clks <= cnt + CNT_W'(1);
                cnt       <= '0;
            end else begin
                done <= 1'b0;
                cnt  <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/cbr_exec_chk.sv
module cbr_exec_chk
    import cbr_pkg::*;
#(
    parameter int PCW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic [7:0]       done_op,
    input logic [CNT_W-1:0] done_clks,
    input logic [PCW-1:0]   pc,
    input logic             cy,
    input logic             ram_we,
    input logic [7:0]       op_q,
    input logic [7:0]       acc,
    input logic [PCW-1:0]   dptr
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc == '0 && !cy && !done));

    a_r2_clock_count: assert property (@(posedge clk) disable iff (rst)
        done |-> done_clks == CNT_W'(int'(decode_op(done_op).ncyc) * CLKS_PER_IC));

    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_idle_step: assert property (@(posedge clk) disable iff (rst)
        (done && (done_op == 8'h00 || done_op == 8'hA5)) |-> pc == $past(pc) + PCW'(1));

    a_r10_indirect_jump: assert property (@(posedge clk) disable iff (rst)
        (done && done_op == 8'h73) |-> pc == PCW'($past(acc)) + $past(dptr));

    a_r12_carry_hold: assert property (@(posedge clk) disable iff (rst)
        (done && done_op[7:2] != 6'b101101 && done_op[7:3] != 5'b10111) |-> cy == $past(cy));

    a_r12_write_source: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (op_q == 8'h10 || op_q == 8'hD5 || op_q[7:3] == 5'b11011));

    a_r12_write_once: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> !ram_we);
endmodule

bind cbr_exec cbr_exec_chk #(.PCW(PCW)) u_chk (
    .clk(clk), .rst(rst), .done(done), .done_op(done_op), .done_clks(done_clks),
    .pc(pc), .cy(cy), .ram_we(ram_we), .op_q(op_q), .acc(acc), .dptr(dptr)
);

// File: tb/cbr_exec_bench.sv
module cbr_exec_bench;
    import cbr_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [15:0]      code_addr, dptr, pc;
    logic [7:0]       code_data, ram_addr, ram_rdata, ram_wdata, acc, done_op;
    logic             ram_we, cy, done;
    logic [1:0]       bank;
    logic [CNT_W-1:0] done_clks;

    logic [7:0] cmem [256];
    logic [7:0] dram [256];
    logic       pre_we = 1'b0;
    logic [7:0] pre_a = 8'h00, pre_d = 8'h00;

    cbr_exec u_cbr_exec (
        .clk(clk), .rst(rst), .code_addr(code_addr), .code_data(code_data),
        .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .acc(acc), .dptr(dptr), .bank_sel(bank), .pc(pc), .cy(cy),
        .done(done), .done_op(done_op), .done_clks(done_clks)
    );

    always @(posedge clk) begin
        code_data <= cmem[code_addr[7:0]];
        if (pre_we)      dram[pre_a]    <= pre_d;
        else if (ram_we) dram[ram_addr] <= ram_wdata;
        ram_rdata <= dram[ram_addr];
    end

    int nchk = 0, nerr = 0;
    logic [15:0] mpc;
    logic        mcy;
    logic [7:0]  mram [256];
    logic [7:0]  mop;
    int          exp_clks;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        pre_a = a; pre_d = d; pre_we = 1'b1;
        mram[a] = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic emit(input logic [7:0] a, input logic [7:0] x, input logic [7:0] y, input logic [7:0] z);
        cmem[a] = x; cmem[8'(a + 8'd1)] = y; cmem[8'(a + 8'd2)] = z;
    endtask

    function automatic string pc_tag(input logic [7:0] op);
        if (op == 8'h60 || op == 8'h70) return "R4 R11";
        if (op == 8'h30 || op == 8'h10) return "R5";
        if (op == 8'hB4 || op == 8'hB5) return "R6";
        if (op >= 8'hB6 && op <= 8'hBF) return "R9 R6";
        if (op >= 8'hD8)                return "R9 R8 R11";
        if (op == 8'hD5)                return "R8 R11";
        if (op == 8'h73)                return "R10";
        return "R3";
    endfunction

    // reference model: executes one whole instruction on the model state
    task automatic model_step();
        logic [7:0] op, b1, b2, rel, v1, v2, p, ba, a;
        logic [2:0] bi;
        logic       take, jind;
        int         len, ic;
        logic [15:0] seq;
        op = cmem[mpc[7:0]];
        b1 = cmem[8'(mpc + 16'd1)];
        b2 = cmem[8'(mpc + 16'd2)];
        len = 1; ic = 1; take = 1'b0; rel = b1; jind = 1'b0;
        case (op) inside
            8'h60: begin len = 2; ic = 3; take = (acc == 8'h00); end
            8'h70: begin len = 2; ic = 3; take = (acc != 8'h00); end
            8'h30, 8'h10: begin
                len = 3; ic = 4; rel = b2;
                ba = 8'h20 + {4'h0, b1[6:3]};
                bi = b1[2:0];
                take = (op == 8'h30) ? !mram[ba][bi] : mram[ba][bi];
                if (op == 8'h10 && mram[ba][bi]) mram[ba][bi] = 1'b0;
            end
            [8'hB4:8'hBF]: begin
                len = 3; ic = 4; rel = b2;
                if (op == 8'hB4)      begin v1 = acc; v2 = b1; end
                else if (op == 8'hB5) begin v1 = acc; v2 = mram[b1]; end
                else if (op <= 8'hB7) begin
                    p = mram[{3'b000, bank, 2'b00, op[0]}];
                    v1 = mram[p]; v2 = b1;
                end else begin v1 = mram[{3'b000, bank, op[2:0]}]; v2 = b1; end
                take = (v1 != v2);
                mcy  = (v1 < v2);
            end
            [8'hD8:8'hDF]: begin
                len = 2; ic = 3;
                a = {3'b000, bank, op[2:0]};
                mram[a] = mram[a] - 8'd1;
                take = (mram[a] != 8'h00);
            end
            8'hD5: begin
                len = 3; ic = 4; rel = b2;
                mram[b1] = mram[b1] - 8'd1;
                take = (mram[b1] != 8'h00);
            end
            8'h73: begin ic = 3; jind = 1'b1; end
            default: ;
        endcase
        seq = mpc + 16'(len);
        if (jind)      mpc = 16'(acc) + dptr;
        else if (take) mpc = seq + {{8{rel[7]}}, rel};
        else           mpc = seq;
        exp_clks = ic * 4;
        mop = op;
    endtask

    initial begin
        int  k, cycles;
        bit  finished;
        bit  ram_ok;
        for (int i = 0; i < 256; i++) cmem[i] = 8'h00;
        acc = 8'h00; dptr = 16'h0040; bank = 2'd0;
        mpc = 16'h0000; mcy = 1'b0;

        // program, phase 1 (bank 0, acc 0)
        cmem[8'h01] = 8'hA5;                    // R3 reserved no-op
        emit(8'h02, 8'h60, 8'h03, 8'h00);       // taken zero test
        emit(8'h07, 8'h70, 8'h05, 8'h00);       // not taken
        emit(8'h09, 8'hB4, 8'h10, 8'h02);       // acc < imm -> cy set, taken
        emit(8'h0E, 8'hD8, 8'hFE, 8'h00);       // R11 backward loop on R0
        emit(8'h10, 8'h30, 8'h05, 8'h02);       // bit set -> not taken
        emit(8'h13, 8'h10, 8'h05, 8'h01);       // bit set -> clear, taken
        emit(8'h17, 8'h10, 8'h05, 8'h01);       // bit now clear -> no write
        emit(8'h1A, 8'h30, 8'h85, 8'h03);       // bit 7 of address ignored
        emit(8'h20, 8'hB5, 8'h30, 8'h00);       // equal -> cy clear
        emit(8'h23, 8'hB7, 8'h40, 8'h00);       // through R1 pointer
        emit(8'h26, 8'hBA, 8'h07, 8'h02);       // R2 equal
        emit(8'h29, 8'hD5, 8'h32, 8'h02);       // 1 -> 0 falls through
        emit(8'h2C, 8'hD5, 8'h33, 8'hFD);       // loop twice on direct byte
        emit(8'h2F, 8'h73, 8'h00, 8'h00);       // acc+dptr -> 0x40
        // phase 2 (bank 1, acc 0x55)
        emit(8'h40, 8'h60, 8'h10, 8'h00);
        emit(8'h42, 8'h70, 8'h02, 8'h00);
        emit(8'h46, 8'hD9, 8'h02, 8'h00);
        emit(8'h48, 8'hBB, 8'h60, 8'hF0);
        emit(8'h4B, 8'hB4, 8'h60, 8'h03);
        emit(8'h51, 8'hB6, 8'h55, 8'h02);
        emit(8'h54, 8'hB5, 8'h35, 8'h7F);       // largest forward offset
        cmem[8'hD6] = 8'h12;                    // unlisted opcode acts as no-op
        cmem[8'hD7] = 8'h73;                    // -> 0xD8, end of program

        for (int i = 0; i < 256; i++) poke(8'(i), 8'h00);
        poke(8'h00, 8'h03); poke(8'h01, 8'h31); poke(8'h02, 8'h07);
        poke(8'h08, 8'h34); poke(8'h09, 8'h01); poke(8'h0B, 8'h60);
        poke(8'h20, 8'h20); poke(8'h31, 8'h80); poke(8'h32, 8'h01);
        poke(8'h33, 8'h02); poke(8'h34, 8'h55); poke(8'h35, 8'h10);

        @(negedge clk);
        chk(pc == 16'h0000, "R1 pc", 32'(pc), 0);
        chk(cy == 1'b0, "R1 cy", 32'(cy), 0);
        chk(done == 1'b0, "R1 done", 32'(done), 0);
        chk(code_addr == 16'h0000, "R1 fetch", 32'(code_addr), 0);
        rst = 1'b0;

        model_step();
        k = 0; cycles = 0; finished = 0;
        while (!finished) begin
            @(negedge clk);
            cycles++; k++;
            chk(done == (k == exp_clks), "R2 done timing", 32'(done), 32'(k == exp_clks));
            if (done) begin
                chk(pc == mpc, pc_tag(mop), 32'(pc), 32'(mpc));
                chk(cy == mcy, (mop >= 8'hB4 && mop <= 8'hBF) ? "R7 cy" : "R12 cy", 32'(cy), 32'(mcy));
                chk(done_clks == CNT_W'(exp_clks), "R2 clocks", 32'(done_clks), 32'(exp_clks));
                chk(done_op == mop, "R2 opcode", 32'(done_op), 32'(mop));
                ram_ok = 1'b1;
                for (int i = 0; i < 256; i++) if (dram[i] !== mram[i]) ram_ok = 1'b0;
                chk(ram_ok, (mop == 8'h10) ? "R5 ram" : "R8 R12 ram", 32'(ram_ok), 1);
                k = 0;
                if (mpc == 16'h0040) begin acc = 8'h55; bank = 2'd1; dptr = 16'h0083; end
                if (mpc == 16'h00D8) finished = 1;
                else model_step();
            end
            if (cycles > 20000) begin
                chk(1'b0, "R2 watchdog", 32'(cycles), 20000);
                finished = 1;
            end
        end
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule